// File: doc/BRIEF.md
# Swap-Cell Multiplexer Tree with Parity Monitor

This block selects one of `2^m` data bits with an `m`-bit select, using only three-in, three-out controlled-swap cells wired as a binary tree. Each cell passes its control bit through unchanged. It routes its two data bits straight or crossed, depending on that control. Because of this, each cell keeps the number of ones on its outputs equal to the number on its inputs. The block brings every cell output that the tree does not consume out to a garbage bus. Nothing is dropped, so the total ones count of all block inputs equals that of all block outputs.

The select bits are not fanned out. The lowest select enters the first cell of the leaf level. Each cell hands its passed-through control to the next cell on the same level, and the last cell of each level puts it on the garbage bus. A parity monitor compares the XOR of every primary input with the XOR of every primary output and flags any difference. A test-only fault port can invert the data output of one chosen cell, to show that the monitor responds.

The block is purely combinational. Data is presented and the result is read in the same cycle, so there is no handshake and no back-pressure. The per-cell cost of 5 units gives a tree cost of `5*(2^m-1)`. The package computes this constant.

Top module: `cmx_swap_tree`

## Requirements
- R1: With `fault_en_i` low, `out_o` equals `data_i[sel_i]` for every data and select value.
- R2: Cells are indexed level by level from the leaves, with leaf cell `p` taking `data_i[2p]` and `data_i[2p+1]` under `sel_i[0]`. Bit `c` of `garb_o` (for `c` below `2^m-1`) carries the unselected data bit of cell `c`. So for a leaf cell, `garb_o[p]` is `data_i[2p+1]` when `sel_i[0]` is 0 and `data_i[2p]` when it is 1.
- R3: `garb_o` is `2^m+m-1` bits wide, and bit `2^m-1+l` carries the pass-through of `sel_i[l]` for each level `l`.
- R4: With `fault_en_i` low, the count of ones in `{data_i, sel_i}` equals the count of ones in `{out_o, garb_o}`.
- R5: With `fault_en_i` low, `err_o` is 0 for every input.
- R6: With `fault_en_i` high and `fault_cell_i` naming an existing cell (0 to `2^m-2`), `err_o` is 1. When the named cell is the root (`2^m-2`), `out_o` is the inverse of `data_i[sel_i]`.
- R7: With `fault_en_i` high and `fault_cell_i` equal to `2^m-1`, which names no cell, `err_o` is 0 and `out_o` equals `data_i[sel_i]`.
- R8: While `fault_en_i` is low, any value on `fault_cell_i` leaves `out_o`, `garb_o` and `err_o` unchanged.
- R9: The package gives the tree cost as `5*(2^m-1)` (35 for `m`=3), the cell count as `2^m-1` and the garbage width as `2^m+m-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 2^SEL_W | Data bits to choose from |
| sel_i | input | SEL_W | Index of the bit to pass to `out_o` |
| fault_en_i | input | 1 | Test only: enable inversion of one cell's data output |
| fault_cell_i | input | SEL_W | Test only: index of the cell to corrupt |
| out_o | output | 1 | Selected data bit |
| garb_o | output | 2^SEL_W+SEL_W-1 | Unconsumed cell outputs: unselected bits, then select pass-throughs |
| err_o | output | 1 | Input/output parity mismatch flag |

## Verification
The bench sweeps every data pattern against every select value. A tree whose levels used the select bits in the wrong order would pass the wrong index. A cell with its swap sense inverted would return the neighbour bit. A dropped garbage wire would break the ones-count equality and raise `err_o` falsely.

Fault injection is driven on each cell in turn. A monitor that covers only part of the outputs would miss faults in some cells. A decoder that wraps the out-of-range index onto a real cell would raise the flag on the idle value `2^m-1`. A fault gate that ignores its enable would corrupt results while the enable is low.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int CELL_COST = 5;

  function automatic int tree_cells(input int m);
    return (1 << m) - 1;
  endfunction

  function automatic int garb_bits(input int m);
    return (1 << m) + m - 1;
  endfunction

  function automatic int tree_cost(input int m);
    return CELL_COST * tree_cells(m);
  endfunction
endpackage

// File: rtl/cmx_swap_cell.sv
// Controlled swap cell: control passes through; data goes straight on 0, crossed on 1.
module cmx_swap_cell (
  input  logic ctrl_i,
  input  logic a_i,
  input  logic b_i,
  input  logic flip_i,
  output logic ctrl_o,
  output logic pick_o,
  output logic rest_o
);
  logic pick_raw;

  always_comb begin
    ctrl_o   = ctrl_i;
    pick_raw = ctrl_i ? b_i : a_i;
    rest_o   = ctrl_i ? a_i : b_i;
    pick_o   = pick_raw ^ flip_i;
  end
endmodule

// File: rtl/cmx_parity_mon.sv
// Flags a parity difference between the full input set and the full output set.
module cmx_parity_mon #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  src_i,
  input  logic [OUT_W-1:0] dst_i,
  output logic             err_o
);
  logic src_par;
  logic dst_par;

  always_comb begin
    src_par = ^src_i;
    dst_par = ^dst_i;
    err_o   = src_par ^ dst_par;
  end
endmodule

// File: rtl/cmx_swap_tree.sv
module cmx_swap_tree #(
  parameter  int SEL_W  = 3,
  localparam int N      = 1 << SEL_W,
  localparam int CELLS  = N - 1,
  localparam int GARB_W = N + SEL_W - 1
) (
  input  logic [N-1:0]      data_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              fault_en_i,
  input  logic [SEL_W-1:0]  fault_cell_i,
  output logic              out_o,
  output logic [GARB_W-1:0] garb_o,
  output logic              err_o
);
  localparam int TREE_COST = cmx_pkg::tree_cost(SEL_W);

  // node[0..N-1] are data inputs; node[N+c] is the data output of cell c.
  logic [2*N-2:0]   node;
  logic [CELLS-1:0] ctl_out;
  logic [CELLS-1:0] rest;

  assign node[N-1:0] = data_i;

  for (genvar lv = 0; lv < SEL_W; lv++) begin : g_lvl
    localparam int LV_CELLS = N >> (lv + 1);
    localparam int BASE     = N - (N >> lv);
    localparam int INB      = 2*N - 2*(N >> lv);

    for (genvar p = 0; p < LV_CELLS; p++) begin : g_cell
      localparam int C = BASE + p;
      logic ctl_in;
      logic flip;

      if (p == 0) begin : g_head
        assign ctl_in = sel_i[lv];
      end else begin : g_chain
        assign ctl_in = ctl_out[C-1];
      end

      assign flip = fault_en_i && (fault_cell_i == SEL_W'(C));

      cmx_swap_cell u_cell (
        .ctrl_i (ctl_in),
        .a_i    (node[INB + 2*p]),
        .b_i    (node[INB + 2*p + 1]),
        .flip_i (flip),
        .ctrl_o (ctl_out[C]),
        .pick_o (node[N + C]),
        .rest_o (rest[C])
      );
    end

    assign garb_o[CELLS + lv] = ctl_out[BASE + LV_CELLS - 1];
  end

  assign garb_o[CELLS-1:0] = rest;
  assign out_o             = node[2*N-2];

  cmx_parity_mon #(
    .IN_W  (N + SEL_W),
    .OUT_W (1 + GARB_W)
  ) u_mon (
    .src_i ({data_i, sel_i}),
    .dst_i ({out_o, garb_o}),
    .err_o (err_o)
  );
endmodule

// File: rtl/cmx_swap_tree_chk.sv
module cmx_swap_tree_chk #(
  parameter  int SEL_W  = 3,
  localparam int N      = 1 << SEL_W,
  localparam int CELLS  = N - 1,
  localparam int GARB_W = N + SEL_W - 1
) (
  input logic [N-1:0]      data_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic              fault_en_i,
  input logic [SEL_W-1:0]  fault_cell_i,
  input logic              out_o,
  input logic [GARB_W-1:0] garb_o,
  input logic              err_o
);
  always_comb begin
    if (!fault_en_i) begin
      assert_pick_R1: assert (out_o == data_i[sel_i])
        else $error("R1 selected bit mismatch");
      assert_ones_R4: assert ($countones({data_i, sel_i}) == $countones({out_o, garb_o}))
        else $error("R4 ones count not conserved");
      assert_quiet_R5: assert (!err_o)
        else $error("R5 parity flag without fault");
    end
    if (fault_en_i && (int'(fault_cell_i) < CELLS)) begin
      assert_flag_R6: assert (err_o)
        else $error("R6 injected fault not flagged");
    end
    for (int l = 0; l < SEL_W; l++) begin
      assert_ctl_R3: assert (garb_o[CELLS + l] == sel_i[l])
        else $error("R3 select pass-through mismatch");
    end
  end
endmodule

bind cmx_swap_tree cmx_swap_tree_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_cmx_swap_tree.sv
module tb_cmx_swap_tree;
  localparam int SEL_W  = 3;
  localparam int N      = 1 << SEL_W;
  localparam int CELLS  = N - 1;
  localparam int GARB_W = N + SEL_W - 1;

  logic              clk = 1'b0;
  logic [N-1:0]      data_i = '0;
  logic [SEL_W-1:0]  sel_i = '0;
  logic              fault_en_i = 1'b0;
  logic [SEL_W-1:0]  fault_cell_i = '0;
  logic              out_o;
  logic [GARB_W-1:0] garb_o;
  logic              err_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  cmx_swap_tree #(.SEL_W(SEL_W)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] d, input logic [SEL_W-1:0] s,
                       input logic fe, input logic [SEL_W-1:0] fc);
    @(negedge clk);
    data_i = d; sel_i = s; fault_en_i = fe; fault_cell_i = fc;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state();
    apply('0, '0, 1'b0, '0);
    chk(out_o == 1'b0, "R1 idle out", int'(out_o), 0);
    chk(garb_o == '0, "R3 idle garbage", int'(garb_o), 0);
    chk(err_o == 1'b0, "R5 idle err", int'(err_o), 0);
  endtask

  task automatic t_sweep();
    for (int d = 0; d < (1 << N); d++) begin
      for (int s = 0; s < N; s++) begin
        logic [N-1:0] dv;
        dv = N'(d);
        apply(dv, SEL_W'(s), 1'b0, '0);
        chk(out_o == dv[s], "R1 select", int'(out_o), int'(dv[s]));
        chk(err_o == 1'b0, "R5 no fault", int'(err_o), 0);
        chk($countones({dv, SEL_W'(s)}) == $countones({out_o, garb_o}), "R4 ones",
            $countones({out_o, garb_o}), $countones({dv, SEL_W'(s)}));
        for (int l = 0; l < SEL_W; l++) begin
          chk(garb_o[CELLS + l] == s[l], "R3 select pass", int'(garb_o[CELLS + l]), int'(s[l]));
        end
        for (int p = 0; p < N/2; p++) begin
          logic expg;
          expg = s[0] ? dv[2*p] : dv[2*p+1];
          chk(garb_o[p] == expg, "R2 leaf unselected", int'(garb_o[p]), int'(expg));
        end
      end
    end
  endtask

  task automatic t_fault_each_cell();
    for (int c = 0; c < CELLS; c++) begin
      apply(8'b1011_0010, 3'd5, 1'b1, SEL_W'(c));
      chk(err_o == 1'b1, "R6 fault flagged", int'(err_o), 1);
    end
    apply(8'b0010_0000, 3'd5, 1'b1, SEL_W'(CELLS - 1));
    chk(out_o == 1'b0, "R6 root inverts out", int'(out_o), 0);
    apply(8'b0000_0000, 3'd2, 1'b1, SEL_W'(CELLS - 1));
    chk(out_o == 1'b1, "R6 root inverts zero", int'(out_o), 1);
  endtask

  task automatic t_fault_none();
    apply(8'b0100_0000, 3'd6, 1'b1, SEL_W'(CELLS));
    chk(err_o == 1'b0, "R7 idle index err", int'(err_o), 0);
    chk(out_o == 1'b1, "R7 idle index out", int'(out_o), 1);
  endtask

  task automatic t_fault_disabled();
    logic [GARB_W-1:0] g_ref;
    logic              o_ref;
    apply(8'b1100_1010, 3'd3, 1'b0, '0);
    g_ref = garb_o; o_ref = out_o;
    for (int c = 0; c < N; c++) begin
      apply(8'b1100_1010, 3'd3, 1'b0, SEL_W'(c));
      chk(out_o == o_ref && out_o == 1'b1, "R8 out unchanged", int'(out_o), 1);
      chk(garb_o == g_ref, "R8 garbage unchanged", int'(garb_o), int'(g_ref));
      chk(err_o == 1'b0, "R8 err unchanged", int'(err_o), 0);
    end
  endtask

  task automatic t_constants();
    chk(cmx_pkg::tree_cost(SEL_W) == 35, "R9 cost", cmx_pkg::tree_cost(SEL_W), 35);
    chk(cmx_pkg::tree_cells(SEL_W) == 7, "R9 cells", cmx_pkg::tree_cells(SEL_W), 7);
    chk(cmx_pkg::garb_bits(2) == 5, "R9 garbage m2", cmx_pkg::garb_bits(2), 5);
    chk($bits(garb_o) == 10, "R3 garbage width", $bits(garb_o), 10);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_constants();
    t_sweep();
    t_fault_each_cell();
    t_fault_none();
    t_fault_disabled();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule